// File: doc/BRIEF.md
# Pipeline Exception Status Tracker

This block follows the completion status of every instruction through a five-stage pipeline and keeps a faulting instruction from being followed by visible side effects. It classifies each fetched instruction from three fetch-side flags, carries the resulting status code through decode and execute, and lets the memory stage turn it into a bad-address code when the data access fails. The status held in the write-back stage is the status the processor reports to the outside.

From the statuses held in the later stages the block derives four control outputs. They enable the condition-code write and the data-memory write, bubble the memory-stage register, and stall the write-back register. As soon as a fault is visible in memory or write-back, every younger instruction loses its ability to change architectural state in that same cycle. A branch-recovery cancel input turns the decode and execute entries into bubbles, so a bad instruction fetched on a wrong path never gets reported.

Top module: `exc_status_pipe`

## Requirements
- R1: Status codes are 3 bits wide: normal=1, halt=2, bad address=3, illegal instruction=4, bubble=5. Reset loads the bubble code into every stage register.
- R2: The fetch status uses a fixed priority. An instruction-memory error gives bad address. Otherwise, an instruction flagged not valid gives illegal instruction. Otherwise, a halt opcode gives halt. Otherwise the status is normal.
- R3: The status of an instruction fetched in cycle c reaches write-back, and so the reported status, in cycle c+4. Decode and execute pass it on unchanged.
- R4: A data-memory error while an instruction is in the memory stage replaces that instruction's status with bad address, whatever it was before. Without an error, the memory stage passes the status on unchanged.
- R5: The reported status equals the write-back status, except that bubble is reported as normal.
- R6: `cc_wr_en` is high only when `ex_is_alu` is high and neither the memory-stage status (after R4) nor the write-back status is halt, bad address or illegal instruction.
- R7: `mem_bubble` is high whenever the memory-stage status (after R4) or the write-back status is exceptional. The memory register then takes the bubble code at the next edge.
- R8: `wb_stall` is high whenever the write-back status is exceptional. The write-back register then keeps the faulting status until reset.
- R9: `dmem_wr_en` equals `mem_wr_req`, forced low when the memory-stage status (after R4) or the write-back status is exceptional.
- R10: `cancel` high in a cycle loads bubble into the decode and execute registers at the next edge. An invalid instruction cancelled this way is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_imem_err | input | 1 | Instruction memory access failed for the fetched instruction |
| if_instr_ok | input | 1 | Fetched opcode is a legal instruction |
| if_is_halt | input | 1 | Fetched opcode is halt |
| cancel | input | 1 | Branch recovery: squash decode and execute entries |
| ex_is_alu | input | 1 | Instruction in execute is an arithmetic/logic operation |
| mem_dmem_err | input | 1 | Data memory access of the memory-stage instruction failed |
| mem_wr_req | input | 1 | Memory-stage instruction requests a data write |
| arch_stat | output | 3 | Reported processor status |
| cc_wr_en | output | 1 | Condition-code write enable |
| dmem_wr_en | output | 1 | Gated data-memory write enable |
| mem_bubble | output | 1 | Memory-stage register bubbled at next edge |
| wb_stall | output | 1 | Write-back register held |

## Verification
A wrong status in an internal stage register shows up at `arch_stat` in at most four cycles, when that entry reaches write-back. In memory or write-back it shows up in the same cycle, through the gating outputs `cc_wr_en`, `dmem_wr_en` and `mem_bubble`. The stimulus aims at the cycles where these meet: an add in execute next to a failing store, a halt that later gets a memory error, and a wrong-path invalid fetch that is cancelled while in decode. A write-back register that fails to hold would show as the reported status dropping back to normal several cycles after a fault.

// File: rtl/exc_status_pkg.sv
package exc_status_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_OK  = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4,
        ST_BUB = 3'd5
    } stat_t;

    function automatic logic is_exc(input stat_t s);
        return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INS);
    endfunction

    function automatic stat_t fetch_classify(input logic imem_err,
                                             input logic instr_ok,
                                             input logic is_halt);
        if (imem_err)       return ST_ADR;
        else if (!instr_ok) return ST_INS;
        else if (is_halt)   return ST_HLT;
        else                return ST_OK;
    endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bubble,
    input  logic  stall,
    input  stat_t d,
    output stat_t q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= ST_BUB;
        else if (bubble) q <= ST_BUB;
        else if (!stall) q <= d;
    end

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (stall && !bubble) |=> q == $past(q));
    a_r7_bubble_loads: assert property (@(posedge clk) disable iff (rst)
        bubble |=> q == ST_BUB);
endmodule

// File: rtl/exc_gate_ctl.sv
module exc_gate_ctl
    import exc_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t m_q,
    input  logic  dmem_err,
    input  stat_t w_q,
    input  logic  ex_is_alu,
    input  logic  wr_req,
    output stat_t m_out,
    output logic  cc_we,
    output logic  dmem_we,
    output logic  m_bub,
    output logic  w_stl
);
    logic fault_seen;

    always_comb begin
        m_out      = dmem_err ? ST_ADR : m_q;
        fault_seen = is_exc(m_out) || is_exc(w_q);
        cc_we      = ex_is_alu && !fault_seen;
        dmem_we    = wr_req && !fault_seen;
        m_bub      = fault_seen;
        w_stl      = is_exc(w_q);
    end

    a_r6_cc_blocked_by_wb: assert property (@(posedge clk) disable iff (rst)
        cc_we |-> !is_exc(w_q));
    a_r9_write_needs_req: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (wr_req && !dmem_err));
    a_r4_dmem_err_marks: assert property (@(posedge clk) disable iff (rst)
        (dmem_err && !is_exc(w_q)) |=> w_q == ST_ADR);
endmodule

// File: rtl/exc_status_pipe.sv
module exc_status_pipe
    import exc_status_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  if_imem_err,
    input  logic                  if_instr_ok,
    input  logic                  if_is_halt,
    input  logic                  cancel,
    input  logic                  ex_is_alu,
    input  logic                  mem_dmem_err,
    input  logic                  mem_wr_req,
    output logic [STAT_W-1:0]     arch_stat,
    output logic                  cc_wr_en,
    output logic                  dmem_wr_en,
    output logic                  mem_bubble,
    output logic                  wb_stall
);
    stat_t f_stat, d_q, e_q, m_q, m_out, w_q;

    always_comb f_stat = fetch_classify(if_imem_err, if_instr_ok, if_is_halt);

    exc_stage_reg u_dreg (.clk(clk), .rst(rst), .bubble(cancel), .stall(1'b0),
                          .d(f_stat), .q(d_q));
    exc_stage_reg u_ereg (.clk(clk), .rst(rst), .bubble(cancel), .stall(1'b0),
                          .d(d_q), .q(e_q));
    exc_stage_reg u_mreg (.clk(clk), .rst(rst), .bubble(mem_bubble), .stall(1'b0),
                          .d(e_q), .q(m_q));
    exc_stage_reg u_wreg (.clk(clk), .rst(rst), .bubble(1'b0), .stall(wb_stall),
                          .d(m_out), .q(w_q));

    exc_gate_ctl u_gate (
        .clk(clk), .rst(rst), .m_q(m_q), .dmem_err(mem_dmem_err), .w_q(w_q),
        .ex_is_alu(ex_is_alu), .wr_req(mem_wr_req), .m_out(m_out),
        .cc_we(cc_wr_en), .dmem_we(dmem_wr_en), .m_bub(mem_bubble), .w_stl(wb_stall)
    );

    always_comb arch_stat = (w_q == ST_BUB) ? ST_OK : w_q;

    a_r5_never_report_bubble: assert property (@(posedge clk) disable iff (rst)
        arch_stat != ST_BUB);
    a_r10_cancel_squashes: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (e_q == ST_BUB && d_q == ST_BUB));
    a_r8_fault_sticks: assert property (@(posedge clk) disable iff (rst)
        is_exc(w_q) |=> arch_stat == $past(arch_stat));
endmodule

// File: tb/sim_exc_status_pipe.sv
module sim_exc_status_pipe;
    logic clk = 0, rst = 1;
    logic if_imem_err = 0, if_instr_ok = 1, if_is_halt = 0, cancel = 0;
    logic ex_is_alu = 0, mem_dmem_err = 0, mem_wr_req = 0;
    logic [2:0] arch_stat;
    logic cc_wr_en, dmem_wr_en, mem_bubble, wb_stall;

    exc_status_pipe u0 (.*);

    always #5 clk = ~clk;

    typedef struct { int cyc; int kind; int val; string req; } exp_t;
    exp_t sb[$];
    int cyc = 0, n_run = 0, n_fail = 0;
    bit done = 0;

    function automatic int observe(int kind);
        case (kind)
            0: return int'(arch_stat);
            1: return int'(cc_wr_en);
            2: return int'(dmem_wr_en);
            3: return int'(mem_bubble);
            default: return int'(wb_stall);
        endcase
    endfunction

    task automatic expect_at(int c, int kind, int val, string req);
        exp_t e;
        e.cyc = c; e.kind = kind; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compares scoreboard entries due in the current cycle
    always @(negedge clk) begin
        #3;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                n_run++;
                if (observe(sb[i].kind) != sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d",
                             sb[i].req, cyc, sb[i].kind, observe(sb[i].kind), sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step(bit ie = 0, bit ok = 1, bit hl = 0, bit alu = 0,
                        bit derr = 0, bit wr = 0, bit cx = 0);
        @(negedge clk);
        cyc++;
        #1;
        if_imem_err = ie; if_instr_ok = ok; if_is_halt = hl; ex_is_alu = alu;
        mem_dmem_err = derr; mem_wr_req = wr; cancel = cx;
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst = 1;
        if_imem_err = 0; if_instr_ok = 1; if_is_halt = 0; ex_is_alu = 0;
        mem_dmem_err = 0; mem_wr_req = 0; cancel = 0;
        @(negedge clk);
        @(negedge clk);
        #1 rst = 0;
        cyc = 0;
    endtask

    task automatic fetch_case(bit ie, bit ok, bit hl, int val, string req);
        do_reset();
        step(ie, ok, hl);
        expect_at(cyc + 4, 0, val, req);
        repeat (4) step();
    endtask

    initial begin
        // R1 / R5: after reset write-back holds bubble, reported as normal
        do_reset();
        step();
        expect_at(cyc, 0, 1, "R1");
        expect_at(cyc, 4, 0, "R5");
        expect_at(cyc, 3, 0, "R1");

        // R3 / R6 / R9: normal flow, ALU writes and a good store go through
        do_reset();
        step(); step(); step();
        step(.alu(1), .wr(1));
        expect_at(cyc, 1, 1, "R6");
        expect_at(cyc, 2, 1, "R9");
        expect_at(cyc, 3, 0, "R7");
        step();
        expect_at(cyc, 0, 1, "R3");

        // R2 priority ordering
        fetch_case(1, 0, 1, 3, "R2");
        fetch_case(0, 0, 1, 4, "R2");
        fetch_case(0, 1, 1, 2, "R2");
        fetch_case(1, 1, 0, 3, "R2");

        // invalid store followed by add: R4 R6 R7 R8 R9
        do_reset();
        step();                      // c1 fetch store
        step();                      // c2 fetch add
        step();                      // c3
        step(.alu(1), .derr(1), .wr(1)); // c4 store in M fails, add in E
        expect_at(cyc, 1, 0, "R6");
        expect_at(cyc, 2, 0, "R9");
        expect_at(cyc, 3, 1, "R7");
        expect_at(cyc, 0, 1, "R3");
        step(.alu(1), .wr(1));       // c5
        expect_at(cyc, 0, 3, "R4");
        expect_at(cyc, 4, 1, "R8");
        expect_at(cyc, 1, 0, "R6");
        expect_at(cyc, 2, 0, "R9");
        expect_at(cyc, 3, 1, "R7");
        repeat (4) step(.alu(1));
        expect_at(cyc, 0, 3, "R8");
        expect_at(cyc, 1, 0, "R6");

        // R4: a halt that meets a data memory error turns into bad address
        do_reset();
        step(.hl(1));
        step(); step();
        step(.derr(1));
        step();
        expect_at(cyc, 0, 3, "R4");

        // R6 / R8: halt in write-back blocks condition codes
        do_reset();
        step(.hl(1));
        repeat (3) step();
        step(.alu(1));
        expect_at(cyc, 0, 2, "R8");
        expect_at(cyc, 1, 0, "R6");
        expect_at(cyc, 4, 1, "R8");

        // R10: wrong-path invalid fetch cancelled in decode
        do_reset();
        step(.ok(0));                // c1 invalid fetched
        step(.cx(1));                // c2 cancelled while in D
        step();
        step(.alu(1));               // c4
        expect_at(cyc, 1, 1, "R10");
        step();                      // c5
        expect_at(cyc, 0, 1, "R10");
        step();
        expect_at(cyc, 0, 1, "R10");
        expect_at(cyc, 4, 0, "R10");

        step(); step();
        if (sb.size() != 0) begin
            n_fail += sb.size();
            $display("FAIL scoreboard: %0d expectations never compared, expected 0", sb.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule